// File: doc/BRIEF.md
# Transition Interface Mutex

This block decides which of two requesters may use a shared set of transition registers: a debug TAP port and a system bus port. Each port takes the mutex by writing a fixed 8-bit true code into its claim register. Only one port can hold the mutex at a time. While a port holds it, that port alone can read the register set and write to it. The other port reads zeros everywhere, so token words can never pass from one port to the other.

The holder writes a target word and a set of token words, then writes the command register to start a transition. The block sends a one-cycle start pulse to the lifecycle engine, which is outside this block. From that point the target, token and command registers are locked until the engine signals completion. A read-only write-enable flag shows the holder whether those registers are currently writable. The holder gives up the mutex by writing zero to its claim register. Reset also releases the mutex.

Each port is modelled as a write strobe with an address and data, plus a combinational read-data output for the same address.

Top module: `txn_mutex_top`

## Requirements
- R1: After reset, neither port owns the mutex, regWen and transStart are 0, and every address reads 0 from both ports.
- R2: A write of exactly 32'h0000_0096 to address 0 (the claim register) from a port, while the mutex is free, makes that port the owner from the next cycle. The owner then reads 8'h96 at address 0 and 1 at address 1 (the write-enable flag), and regWen is 1.
- R3: A claim write with any value other than 32'h0000_0096 leaves the mutex free and regWen at 0. This includes values whose low byte is 8'h96 but whose upper bits are not zero.
- R4: When both ports write the true code to the claim register in the same cycle while the mutex is free, the TAP port becomes the owner.
- R5: A port that does not own the mutex reads 0 at every address. The owner reads the stored contents: address 2 is the target, addresses 3 to 6 are token words 0 to 3, and bit 0 of address 7 is the busy flag.
- R6: While one port owns the mutex, a claim write from the other port has no effect on ownership.
- R7: A write of zero to the claim register by the owner releases the mutex on the next cycle. A write of zero by the non-owner has no effect.
- R8: While regWen is 1, owner writes to the target (address 2) and token (addresses 3 to 6) registers update transTarget and transToken. Token word k sits at bits [32k+31:32k]. Writes to these registers from the non-owner are ignored.
- R9: An owner write to address 7 with data bit 0 set, while regWen is 1, raises transStart for exactly one cycle, starting on the cycle after the write. In that same cycle regWen becomes 0. A write to address 7 with bit 0 clear starts nothing.
- R10: While a transition is in progress, writes to the target, token and command registers are blocked, including a second start. A doneIn pulse ends the operation, and regWen returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tapWe | input | 1 | TAP port write strobe |
| tapAddr | input | 4 | TAP port register address (write and read) |
| tapWdata | input | 32 | TAP port write data |
| tapRdata | output | 32 | TAP port read data, zero unless TAP owns |
| busWe | input | 1 | Bus port write strobe |
| busAddr | input | 4 | Bus port register address (write and read) |
| busWdata | input | 32 | Bus port write data |
| busRdata | output | 32 | Bus port read data, zero unless bus owns |
| doneIn | input | 1 | Transition finished, unlocks registers |
| tapOwner | output | 1 | TAP port holds the mutex |
| busOwner | output | 1 | Bus port holds the mutex |
| regWen | output | 1 | Transition registers writable by the owner |
| transStart | output | 1 | One-cycle transition start pulse |
| transTarget | output | 32 | Stored transition target |
| transToken | output | 128 | Stored token words, word k at bits [32k+31:32k] |

## Verification
The hardest case to reach from the ports is a collision of events in a single cycle. Both ports must present the true code on the same clock edge while the mutex is free. In a separate case, locked writes must land while a transition is pending. The bench drives both ports' strobes inside the same low clock phase to force the tie. It then holds the engine's done input low while it attempts target, token and restart writes, so the locked window stays open as long as needed. Around these cases, the bench sweeps every 8-bit claim value from each port and reads every address from both ports after each change of ownership.

// File: rtl/txn_mutex_pkg.sv
package txn_mutex_pkg;

  localparam logic [7:0] CLAIM_TRUE = 8'h96;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TAP  = 2'd1,
    OWN_BUS  = 2'd2
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrGo;     // owner write to target/token accepted
    logic srcTap;   // owner write comes from TAP port
    logic tapRdOk;  // TAP may see register contents
    logic busRdOk;  // bus may see register contents
  } ctl_strobe_t;

endpackage

// File: rtl/txn_mutex_ctrl.sv
module txn_mutex_ctrl
  import txn_mutex_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int TOKEN_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapWe,
  input  logic [ADDR_W-1:0] tapAddr,
  input  logic [DATA_W-1:0] tapWdata,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              doneIn,
  output ctl_strobe_t       strobe,
  output logic              tapOwner,
  output logic              busOwner,
  output logic              regWen,
  output logic              busy,
  output logic              transStart
);

  localparam int ADDR_CLAIM  = 0;
  localparam int ADDR_TARGET = 2;
  localparam int ADDR_CMD    = 3 + TOKEN_WORDS;
  localparam logic [DATA_W-1:0] TRUE_WORD = DATA_W'(CLAIM_TRUE);

  owner_e ownerQ, ownerD;
  logic   busyQ, startQ;

  logic tapClaimWr, busClaimWr;
  logic tapClaimTrue, busClaimTrue, tapClaimZero, busClaimZero;
  logic              ownerWe, ownerBit0, lockedWr, cmdGo;
  logic [ADDR_W-1:0] ownerAddr;

  assign tapClaimWr   = tapWe && (tapAddr == ADDR_W'(ADDR_CLAIM));
  assign busClaimWr   = busWe && (busAddr == ADDR_W'(ADDR_CLAIM));
  assign tapClaimTrue = tapClaimWr && (tapWdata == TRUE_WORD);
  assign busClaimTrue = busClaimWr && (busWdata == TRUE_WORD);
  assign tapClaimZero = tapClaimWr && (tapWdata == '0);
  assign busClaimZero = busClaimWr && (busWdata == '0);

  always_comb begin
    ownerD = ownerQ;
    unique case (ownerQ)
      OWN_NONE: begin
        if (tapClaimTrue)      ownerD = OWN_TAP;  // TAP wins ties
        else if (busClaimTrue) ownerD = OWN_BUS;
      end
      OWN_TAP:  if (tapClaimZero) ownerD = OWN_NONE;
      OWN_BUS:  if (busClaimZero) ownerD = OWN_NONE;
      default:  ownerD = OWN_NONE;
    endcase
  end

  // select the owning port's write request
  always_comb begin
    ownerWe   = 1'b0;
    ownerAddr = '0;
    ownerBit0 = 1'b0;
    if (ownerQ == OWN_TAP) begin
      ownerWe = tapWe; ownerAddr = tapAddr; ownerBit0 = tapWdata[0];
    end else if (ownerQ == OWN_BUS) begin
      ownerWe = busWe; ownerAddr = busAddr; ownerBit0 = busWdata[0];
    end
  end

  assign lockedWr = ownerWe && !busyQ &&
                    (ownerAddr >= ADDR_W'(ADDR_TARGET)) &&
                    (ownerAddr <= ADDR_W'(ADDR_CMD));
  assign cmdGo    = lockedWr && (ownerAddr == ADDR_W'(ADDR_CMD)) && ownerBit0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= OWN_NONE;
      busyQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      ownerQ <= ownerD;
      startQ <= cmdGo;
      if (cmdGo)       busyQ <= 1'b1;
      else if (doneIn) busyQ <= 1'b0;
    end
  end

  assign tapOwner       = (ownerQ == OWN_TAP);
  assign busOwner       = (ownerQ == OWN_BUS);
  assign regWen         = (ownerQ != OWN_NONE) && !busyQ;
  assign busy           = busyQ;
  assign transStart     = startQ;
  assign strobe.wrGo    = lockedWr && (ownerAddr != ADDR_W'(ADDR_CMD));
  assign strobe.srcTap  = tapOwner;
  assign strobe.tapRdOk = tapOwner;
  assign strobe.busRdOk = busOwner;

  // R3: a non-true claim on a free mutex leaves it free
  assert_bad_claim_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_NONE && !tapClaimTrue && !busClaimTrue) |=> (ownerQ == OWN_NONE));

  // R4: a tied claim goes to the TAP port
  assert_tap_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_NONE && tapClaimTrue && busClaimTrue) |=> tapOwner);

  // R6: the other port cannot steal the mutex
  assert_no_steal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tapOwner && !tapClaimWr) |=> tapOwner);

  // R9: the start output is a single-cycle pulse
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    transStart |=> !transStart);

  // R10: registers stay locked while the start is issued
  assert_locked_at_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    transStart |-> !regWen);

endmodule

// File: rtl/txn_mutex_regs.sv
module txn_mutex_regs
  import txn_mutex_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int TOKEN_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctl_strobe_t                   strobe,
  input  logic [ADDR_W-1:0]             tapAddr,
  input  logic [DATA_W-1:0]             tapWdata,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  input  logic                          busy,
  input  logic                          regWen,
  output logic [DATA_W-1:0]             tapRdata,
  output logic [DATA_W-1:0]             busRdata,
  output logic [DATA_W-1:0]             transTarget,
  output logic [TOKEN_WORDS*DATA_W-1:0] transToken
);

  localparam int ADDR_CLAIM  = 0;
  localparam int ADDR_WEN    = 1;
  localparam int ADDR_TARGET = 2;
  localparam int ADDR_TOKEN0 = 3;
  localparam int ADDR_CMD    = ADDR_TOKEN0 + TOKEN_WORDS;

  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;
  logic [DATA_W-1:0] targetQ;
  logic [DATA_W-1:0] tokenQ [TOKEN_WORDS];

  assign wAddr = strobe.srcTap ? tapAddr  : busAddr;
  assign wData = strobe.srcTap ? tapWdata : busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                               targetQ <= '0;
    else if (strobe.wrGo && wAddr == ADDR_W'(ADDR_TARGET))   targetQ <= wData;
  end

  for (genvar w = 0; w < TOKEN_WORDS; w++) begin : g_token
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                                   tokenQ[w] <= '0;
      else if (strobe.wrGo && wAddr == ADDR_W'(ADDR_TOKEN0 + w))   tokenQ[w] <= wData;
    end
    assign transToken[w*DATA_W +: DATA_W] = tokenQ[w];
  end

  assign transTarget = targetQ;

  // one masked read path per port
  logic [ADDR_W-1:0] rdAddr [2];
  logic              rdOk   [2];
  logic [DATA_W-1:0] rdVal  [2];

  assign rdAddr[0] = tapAddr;
  assign rdAddr[1] = busAddr;
  assign rdOk[0]   = strobe.tapRdOk;
  assign rdOk[1]   = strobe.busRdOk;

  for (genvar p = 0; p < 2; p++) begin : g_read
    always_comb begin
      rdVal[p] = '0;
      if (rdOk[p]) begin
        if (rdAddr[p] == ADDR_W'(ADDR_CLAIM))       rdVal[p] = DATA_W'(CLAIM_TRUE);
        else if (rdAddr[p] == ADDR_W'(ADDR_WEN))    rdVal[p] = DATA_W'(regWen);
        else if (rdAddr[p] == ADDR_W'(ADDR_TARGET)) rdVal[p] = targetQ;
        else if (rdAddr[p] == ADDR_W'(ADDR_CMD))    rdVal[p] = DATA_W'(busy);
        for (int w = 0; w < TOKEN_WORDS; w++)
          if (rdAddr[p] == ADDR_W'(ADDR_TOKEN0 + w)) rdVal[p] = tokenQ[w];
      end
    end
  end

  assign tapRdata = rdVal[0];
  assign busRdata = rdVal[1];

  // R5: the two ports never both see contents
  assert_single_reader_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.tapRdOk && strobe.busRdOk));

  // R10: no target change while busy
  assert_target_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(targetQ));

endmodule

// File: rtl/txn_mutex_top.sv
module txn_mutex_top
  import txn_mutex_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int TOKEN_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tapWe,
  input  logic [ADDR_W-1:0]             tapAddr,
  input  logic [DATA_W-1:0]             tapWdata,
  output logic [DATA_W-1:0]             tapRdata,
  input  logic                          busWe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  input  logic                          doneIn,
  output logic                          tapOwner,
  output logic                          busOwner,
  output logic                          regWen,
  output logic                          transStart,
  output logic [DATA_W-1:0]             transTarget,
  output logic [TOKEN_WORDS*DATA_W-1:0] transToken
);

  ctl_strobe_t strobe;
  logic        busy;

  txn_mutex_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOKEN_WORDS(TOKEN_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .tapWe(tapWe), .tapAddr(tapAddr), .tapWdata(tapWdata),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .doneIn(doneIn), .strobe(strobe),
    .tapOwner(tapOwner), .busOwner(busOwner), .regWen(regWen),
    .busy(busy), .transStart(transStart)
  );

  txn_mutex_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOKEN_WORDS(TOKEN_WORDS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tapAddr(tapAddr), .tapWdata(tapWdata),
    .busAddr(busAddr), .busWdata(busWdata),
    .busy(busy), .regWen(regWen),
    .tapRdata(tapRdata), .busRdata(busRdata),
    .transTarget(transTarget), .transToken(transToken)
  );

  // R1/R5: a port without the mutex reads nothing
  assert_bus_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busOwner |-> (busRdata == '0));
  assert_tap_masked_R1: assert property (@(posedge clk) disable iff (!rstN)
    !tapOwner |-> (tapRdata == '0));

  // R8: a bus write does not move the target while TAP owns
  assert_nonowner_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tapOwner && !tapWe && busWe) |=> $stable(transTarget));

endmodule

// File: tb/tb_txn_mutex_top.sv
module tb_txn_mutex_top;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tapWe = 0, busWe = 0, doneIn = 0;
  logic [AW-1:0] tapAddr = '0, busAddr = '0;
  logic [DW-1:0] tapWdata = '0, busWdata = '0;
  logic [DW-1:0] tapRdata, busRdata, transTarget;
  logic [TW*DW-1:0] transToken;
  logic          tapOwner, busOwner, regWen, transStart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  txn_mutex_top #(.DATA_W(DW), .ADDR_W(AW), .TOKEN_WORDS(TW)) dut (
    .clk(clk), .rstN(rstN),
    .tapWe(tapWe), .tapAddr(tapAddr), .tapWdata(tapWdata), .tapRdata(tapRdata),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .doneIn(doneIn), .tapOwner(tapOwner), .busOwner(busOwner), .regWen(regWen),
    .transStart(transStart), .transTarget(transTarget), .transToken(transToken)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic portWrite(input bit isTap, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    if (isTap) begin tapWe = 1; tapAddr = AW'(a); tapWdata = d; end
    else       begin busWe = 1; busAddr = AW'(a); busWdata = d; end
    @(negedge clk);
    tapWe = 0; busWe = 0;
  endtask

  task automatic portRead(input bit isTap, input int a, output logic [DW-1:0] d);
    if (isTap) tapAddr = AW'(a); else busAddr = AW'(a);
    #1;
    d = isTap ? tapRdata : busRdata;
  endtask

  // expected owner-visible value of an address
  function automatic logic [DW-1:0] expRead(input int a, input logic [DW-1:0] tgt,
      input logic [TW*DW-1:0] tok, input bit wen, input bit bsy);
    if (a == 0) return 32'h96;
    if (a == 1) return DW'(wen);
    if (a == 2) return tgt;
    if (a >= 3 && a < 3 + TW) return tok[(a-3)*DW +: DW];
    if (a == 3 + TW) return DW'(bsy);
    return '0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] expTgt;
    logic [TW*DW-1:0] expTok;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk(!tapOwner && !busOwner, "R1", "owners", {tapOwner, busOwner}, 0);
    chk(!regWen, "R1", "regWen", regWen, 0);
    chk(!transStart, "R1", "transStart", transStart, 0);
    for (int a = 0; a < 16; a++) begin
      portRead(1, a, rd); chk(rd == 0, "R1", "tap read", rd, 0);
      portRead(0, a, rd); chk(rd == 0, "R1", "bus read", rd, 0);
    end

    // R2/R3/R7: every low-byte claim value from each port
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        bit expOwn;
        expOwn = (v == 8'h96);
        portWrite(p == 0, 0, DW'(v));
        chk((p == 0 ? tapOwner : busOwner) == expOwn, expOwn ? "R2" : "R3", "claim owner",
            p == 0 ? tapOwner : busOwner, expOwn);
        chk(regWen == expOwn, expOwn ? "R2" : "R3", "claim regWen", regWen, expOwn);
        if (expOwn) begin
          portRead(p == 0, 0, rd); chk(rd == 32'h96, "R2", "claim readback", rd, 32'h96);
          portRead(p == 0, 1, rd); chk(rd == 1, "R2", "wen readback", rd, 1);
          portWrite(p == 0, 0, 0);
          chk(!tapOwner && !busOwner, "R7", "release", {tapOwner, busOwner}, 0);
        end
      end
    end

    // R3: true low byte with upper bits set
    portWrite(0, 0, 32'h0000_0196);
    chk(!busOwner && !regWen, "R3", "upper bits claim", {busOwner, regWen}, 0);
    portWrite(1, 0, 32'h8000_0096);
    chk(!tapOwner && !regWen, "R3", "upper bits claim tap", {tapOwner, regWen}, 0);

    // R4: simultaneous claim
    @(negedge clk);
    tapWe = 1; tapAddr = 0; tapWdata = 32'h96;
    busWe = 1; busAddr = 0; busWdata = 32'h96;
    @(negedge clk);
    tapWe = 0; busWe = 0;
    chk(tapOwner && !busOwner, "R4", "tie winner", {tapOwner, busOwner}, 2'b10);

    // R5: loser reads zeros right after the claim
    for (int a = 0; a < 16; a++) begin
      portRead(0, a, rd); chk(rd == 0, "R5", "loser read", rd, 0);
    end

    // R6/R7: bus cannot steal or release
    portWrite(0, 0, 32'h96);
    chk(tapOwner && !busOwner, "R6", "steal attempt", {tapOwner, busOwner}, 2'b10);
    portWrite(0, 0, 0);
    chk(tapOwner, "R7", "non-owner release", tapOwner, 1);

    // R8: owner writes target and tokens, non-owner ignored
    expTgt = 32'hA5C3_0F11;
    portWrite(1, 2, expTgt);
    expTok = '0;
    for (int w = 0; w < TW; w++) begin
      logic [DW-1:0] tv;
      tv = 32'h1000_0001 * (w + 3) ^ 32'h5A5A_5A5A;
      portWrite(1, 3 + w, tv);
      expTok[w*DW +: DW] = tv;
    end
    chk(transTarget == expTgt, "R8", "target", transTarget, expTgt);
    chk(transToken == expTok, "R8", "tokens", transToken, expTok);
    portWrite(0, 2, 32'hDEAD_BEEF);
    portWrite(0, 4, 32'hDEAD_BEEF);
    chk(transTarget == expTgt, "R8", "bus target ignored", transTarget, expTgt);
    chk(transToken == expTok, "R8", "bus token ignored", transToken, expTok);
    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] e;
      e = expRead(a, expTgt, expTok, 1, 0);
      portRead(1, a, rd); chk(rd == e, "R5", "owner read", rd, e);
      portRead(0, a, rd); chk(rd == 0, "R5", "non-owner read", rd, 0);
    end

    // R9: command with bit0 clear does nothing
    portWrite(1, 3 + TW, 32'h2);
    chk(!transStart && regWen, "R9", "cmd bit0 clear", {transStart, regWen}, 2'b01);

    // R9: start pulse
    portWrite(1, 3 + TW, 32'h1);
    chk(transStart, "R9", "start high", transStart, 1);
    chk(!regWen, "R9", "regWen low at start", regWen, 0);
    @(negedge clk);
    chk(!transStart, "R9", "start one cycle", transStart, 0);
    portRead(1, 3 + TW, rd); chk(rd == 1, "R9", "busy readback", rd, 1);

    // R10: locked while busy
    portWrite(1, 2, 32'h1234_5678);
    chk(transTarget == expTgt, "R10", "target locked", transTarget, expTgt);
    portWrite(1, 5, 32'h1234_5678);
    chk(transToken == expTok, "R10", "token locked", transToken, expTok);
    portWrite(1, 3 + TW, 32'h1);
    chk(!transStart, "R10", "no restart", transStart, 0);
    repeat (5) @(negedge clk);
    chk(!regWen, "R10", "still locked", regWen, 0);
    doneIn = 1;
    @(negedge clk);
    doneIn = 0;
    chk(regWen, "R10", "unlock after done", regWen, 1);
    portWrite(1, 2, 32'h0BAD_F00D);
    chk(transTarget == 32'h0BAD_F00D, "R10", "write after done", transTarget, 32'h0BAD_F00D);

    // R7/R8/R5: hand over to the bus
    portWrite(1, 0, 0);
    chk(!tapOwner, "R7", "tap release", tapOwner, 0);
    portWrite(0, 0, 32'h96);
    chk(busOwner, "R2", "bus claim", busOwner, 1);
    portWrite(0, 2, 32'hCAFE_0042);
    chk(transTarget == 32'hCAFE_0042, "R8", "bus target", transTarget, 32'hCAFE_0042);
    for (int a = 0; a < 16; a++) begin
      portRead(1, a, rd); chk(rd == 0, "R5", "tap masked", rd, 0);
    end
    portWrite(1, 0, 32'h96);
    chk(busOwner && !tapOwner, "R6", "tap steal", {tapOwner, busOwner}, 2'b01);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule